// File: doc/BRIEF.md
# DRAM Block Packer and Unpacker

This block converts between a 72-bit word stream used by packet logic and the 64-bit word stream of a DRAM write/read path. Each 72-bit word holds eight data bytes plus one control byte. On the write side the nine bytes of every word are laid end to end, with no gaps, into 64-bit memory words. Each block of 226 input words (2034 bytes) is then topped up with zero bytes until it fills exactly 256 memory words, one 2 KB DRAM block.

On the read side the reverse is done. The 256 memory words of a block are split back into 226 words of 72 bits. The 14 padding bytes at the tail are discarded and produce no output. Both sides use valid/ready handshakes and carry start-of-block and end-of-block markers. A sticky flag reports input blocks whose framing markers disagree with the fixed block length.

Top module: `dram_blk_codec`

## Requirements
- R1: Write-side byte order. Byte b of an input word sits at wr_data[8b+7:8b]; bytes 0..7 are data and byte 8 is the control byte. Input word w of a block supplies packed bytes 9w..9w+8 in that order. Packed byte k appears in memory word k/8 at bits [8(k%8)+7 : 8(k%8)].
- R2: Every block produces exactly 256 memory words. mw_sob is high on the first of them only, and mw_eob is high on the 256th only.
- R3: Packed bytes 2034 to 2047 are zero. That is bits [63:16] of memory word 254 and all of word 255.
- R4: From the acceptance of the 226th input word until the 256th memory word has been taken, wr_ready stays low.
- R5: With arbitrary stalls on mw_ready and gaps on wr_valid, no byte is lost or repeated. While mw_valid is high and mw_ready low, mw_valid and mw_data hold.
- R6: blk_err goes high and stays high until reset when an accepted input word breaks framing. The cases are: the first word of a block lacks wr_sob; wr_sob appears on a later word; wr_eob appears on a word other than the 226th; or the 226th word lacks wr_eob. Correctly framed blocks leave it low.
- R7: An input word with wr_sob always begins a new block. Partially packed bytes of an unfinished block are dropped, and the memory word count restarts with mw_sob.
- R8: The read side turns the 256 memory words of a block, with mr_sob on the first, into 226 words laid out as in R1. rd_sob is high on the first of these and rd_eob on the last. Bytes 2034..2047 are dropped whatever their value, and no further output follows.
- R9: Under rd_ready stalls the read side loses and repeats nothing. While rd_valid is high and rd_ready low, rd_valid and rd_data hold.
- R10: After reset, wr_ready and mr_ready are high, mw_valid and rd_valid are low, and blk_err is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Input word valid |
| wr_ready | output | 1 | Input word accepted when high with wr_valid |
| wr_data | input | 72 | Eight data bytes plus control byte in bits [71:64] |
| wr_sob | input | 1 | First word of an input block |
| wr_eob | input | 1 | Last word of an input block |
| mw_valid | output | 1 | Memory write word valid |
| mw_ready | input | 1 | Memory side takes the write word |
| mw_data | output | 64 | Packed memory word |
| mw_sob | output | 1 | First memory word of a block |
| mw_eob | output | 1 | 256th memory word of a block |
| mr_valid | input | 1 | Memory read word valid |
| mr_ready | output | 1 | Read word accepted |
| mr_data | input | 64 | Memory word read back |
| mr_sob | input | 1 | First read word of a block |
| rd_valid | output | 1 | Rebuilt word valid |
| rd_ready | input | 1 | Consumer takes the rebuilt word |
| rd_data | output | 72 | Rebuilt data plus control word |
| rd_sob | output | 1 | First rebuilt word of a block |
| rd_eob | output | 1 | 226th rebuilt word of a block |
| blk_err | output | 1 | Sticky framing error |

## Verification
A wrong byte count in the write-side residue shows up as a byte shift in the very next memory word. From there it runs into every word of the block, and it moves the end-of-block marker away from word 256 within the same block. A residue that is not cleared ahead of padding shows up as nonzero tail bytes in word 254 or 255. A read-side counter off by one either leaks a padding byte into word 226 or drops the last control byte, and the output count stops being 226. Checks therefore compare every memory word against arithmetically generated bytes, under both free-running and stalled handshakes, and then loop the captured block back through the read side with its padding overwritten by ones.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  // Number of bytes of memory word idx that still fall inside the packed
  // region of total bytes; the rest of the word is padding.
  function automatic int live_bytes(int total, int idx, int wbytes);
    int rem;
    rem = total - idx * wbytes;
    if (rem >= wbytes) return wbytes;
    else if (rem > 0) return rem;
    return 0;
  endfunction

endpackage

// File: rtl/dbc_packer.sv
module dbc_packer #(
  parameter int DATA_BYTES = 8,
  parameter int CTRL_BYTES = 1,
  parameter int MW_BYTES   = 8,
  parameter int IN_WORDS   = 226,
  parameter int MEM_WORDS  = 256
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_valid,
  output logic                                   in_ready,
  input  logic [(DATA_BYTES+CTRL_BYTES)*8-1:0]   in_data,
  input  logic                                   in_sob,
  input  logic                                   in_eob,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [MW_BYTES*8-1:0]                  out_data,
  output logic                                   out_sob,
  output logic                                   out_eob,
  output logic                                   err
);
  localparam int IN_BYTES  = DATA_BYTES + CTRL_BYTES;
  localparam int MW_W      = MW_BYTES * 8;
  localparam int BUF_BYTES = MW_BYTES + IN_BYTES - 1;
  localparam int BUF_W     = BUF_BYTES * 8;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);
  localparam int IC_W      = $clog2(IN_WORDS + 1);
  localparam int OC_W      = $clog2(MEM_WORDS + 1);

  logic [BUF_W-1:0] buf_q, buf_d, buf_sh, base_buf;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_sh, base_cnt;
  logic [IC_W-1:0]  icnt_q, icnt_d, idx;
  logic [OC_W-1:0]  ocnt_q, ocnt_d;
  logic             pad_q, pad_d, err_q, err_d;
  logic             in_fire, out_fire, restart, last_in, out_last;
  logic             buf_en, cnt_en;

  // Output side: a word is ready whenever eight bytes sit in the residue,
  // and always while padding is being sent.
  always_comb begin
    out_valid = pad_q || (cnt_q >= CNT_W'(MW_BYTES));
    out_fire  = out_valid && out_ready;
    out_last  = (ocnt_q == OC_W'(MEM_WORDS - 1));
    if (out_fire) begin
      buf_sh = buf_q >> MW_W;
      cnt_sh = (cnt_q > CNT_W'(MW_BYTES)) ? cnt_q - CNT_W'(MW_BYTES) : '0;
    end else begin
      buf_sh = buf_q;
      cnt_sh = cnt_q;
    end
    in_ready = !pad_q &&
               (({1'b0, cnt_sh} + (CNT_W+1)'(IN_BYTES)) <= (CNT_W+1)'(BUF_BYTES));
    in_fire  = in_valid && in_ready;
    restart  = in_fire && in_sob;
    idx      = in_sob ? '0 : icnt_q;
    last_in  = (idx == IC_W'(IN_WORDS - 1));
  end

  // Next-state for residue, counters and flags.
  always_comb begin
    base_buf = restart ? '0 : buf_sh;
    base_cnt = restart ? '0 : cnt_sh;
    if (in_fire) begin
      buf_d = base_buf | (BUF_W'(in_data) << {base_cnt, 3'b000});
      cnt_d = base_cnt + CNT_W'(IN_BYTES);
    end else begin
      buf_d = buf_sh;
      cnt_d = cnt_sh;
    end
    buf_en = in_fire || out_fire;
    cnt_en = in_fire || out_fire;

    icnt_d = icnt_q;
    if (in_fire) icnt_d = last_in ? '0 : idx + IC_W'(1);

    ocnt_d = ocnt_q;
    if (restart)       ocnt_d = '0;
    else if (out_fire) ocnt_d = out_last ? '0 : ocnt_q + OC_W'(1);

    pad_d = pad_q;
    if (in_fire && last_in)            pad_d = 1'b1;
    else if (out_fire && out_last)     pad_d = 1'b0;

    err_d = err_q;
    if (in_fire && ((in_sob != (icnt_q == '0)) || (in_eob != last_in)))
      err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      icnt_q <= '0;
      ocnt_q <= '0;
      pad_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (buf_en) buf_q <= buf_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (in_fire) icnt_q <= icnt_d;
      if (restart || out_fire) ocnt_q <= ocnt_d;
      pad_q <= pad_d;
      err_q <= err_d;
    end
  end

  assign out_data = buf_q[MW_W-1:0];
  assign out_sob  = (ocnt_q == '0);
  assign out_eob  = out_last;
  assign err      = err_q;

endmodule

// File: rtl/dbc_unpacker.sv
module dbc_unpacker
  import dbc_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int CTRL_BYTES = 1,
  parameter int MW_BYTES   = 8,
  parameter int IN_WORDS   = 226,
  parameter int MEM_WORDS  = 256
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   mem_valid,
  output logic                                   mem_ready,
  input  logic [MW_BYTES*8-1:0]                  mem_data,
  input  logic                                   mem_sob,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [(DATA_BYTES+CTRL_BYTES)*8-1:0]   out_data,
  output logic                                   out_sob,
  output logic                                   out_eob
);
  localparam int IN_BYTES  = DATA_BYTES + CTRL_BYTES;
  localparam int IN_W      = IN_BYTES * 8;
  localparam int MW_W      = MW_BYTES * 8;
  localparam int BUF_BYTES = MW_BYTES + IN_BYTES - 1;
  localparam int BUF_W     = BUF_BYTES * 8;
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);
  localparam int MI_W      = $clog2(MEM_WORDS + 1);
  localparam int OI_W      = $clog2(IN_WORDS + 1);
  localparam int PACKED    = IN_WORDS * IN_BYTES;

  logic [BUF_W-1:0] buf_q, buf_d, buf_sh, base_buf;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_sh, base_cnt, live_c;
  logic [MI_W-1:0]  midx_q, midx_d, m;
  logic [OI_W-1:0]  oidx_q, oidx_d;
  logic [MW_W-1:0]  masked;
  logic             out_fire, mem_fire, restart, out_last;

  always_comb begin
    out_valid = (cnt_q >= CNT_W'(IN_BYTES));
    out_fire  = out_valid && out_ready;
    out_last  = (oidx_q == OI_W'(IN_WORDS - 1));
    if (out_fire) begin
      buf_sh = buf_q >> IN_W;
      cnt_sh = cnt_q - CNT_W'(IN_BYTES);
    end else begin
      buf_sh = buf_q;
      cnt_sh = cnt_q;
    end
    mem_ready = (({1'b0, cnt_sh} + (CNT_W+1)'(MW_BYTES)) <= (CNT_W+1)'(BUF_BYTES));
    mem_fire  = mem_valid && mem_ready;
    restart   = mem_fire && mem_sob;
    m         = mem_sob ? '0 : midx_q;
    live_c    = CNT_W'(live_bytes(PACKED, int'(m), MW_BYTES));
  end

  // Keep only the bytes that belong to the packed region.
  always_comb begin
    masked = '0;
    for (int b = 0; b < MW_BYTES; b++) begin
      if (CNT_W'(b) < live_c) masked[b*8 +: 8] = mem_data[b*8 +: 8];
    end
  end

  always_comb begin
    base_buf = restart ? '0 : buf_sh;
    base_cnt = restart ? '0 : cnt_sh;
    if (mem_fire) begin
      buf_d = base_buf | (BUF_W'(masked) << {base_cnt, 3'b000});
      cnt_d = base_cnt + live_c;
    end else begin
      buf_d = buf_sh;
      cnt_d = cnt_sh;
    end

    midx_d = midx_q;
    if (mem_fire) midx_d = (m == MI_W'(MEM_WORDS - 1)) ? '0 : m + MI_W'(1);

    oidx_d = oidx_q;
    if (restart)       oidx_d = '0;
    else if (out_fire) oidx_d = out_last ? '0 : oidx_q + OI_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      midx_q <= '0;
      oidx_q <= '0;
    end else begin
      if (mem_fire || out_fire) begin
        buf_q <= buf_d;
        cnt_q <= cnt_d;
      end
      if (mem_fire) midx_q <= midx_d;
      if (restart || out_fire) oidx_q <= oidx_d;
    end
  end

  assign out_data = buf_q[IN_W-1:0];
  assign out_sob  = (oidx_q == '0);
  assign out_eob  = out_last;

endmodule

// File: rtl/dram_blk_codec.sv
module dram_blk_codec #(
  parameter int DATA_BYTES = 8,
  parameter int CTRL_BYTES = 1,
  parameter int MW_BYTES   = 8,
  parameter int IN_WORDS   = 226,
  parameter int MEM_WORDS  = 256
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_valid,
  output logic                                  wr_ready,
  input  logic [(DATA_BYTES+CTRL_BYTES)*8-1:0]  wr_data,
  input  logic                                  wr_sob,
  input  logic                                  wr_eob,
  output logic                                  mw_valid,
  input  logic                                  mw_ready,
  output logic [MW_BYTES*8-1:0]                 mw_data,
  output logic                                  mw_sob,
  output logic                                  mw_eob,
  input  logic                                  mr_valid,
  output logic                                  mr_ready,
  input  logic [MW_BYTES*8-1:0]                 mr_data,
  input  logic                                  mr_sob,
  output logic                                  rd_valid,
  input  logic                                  rd_ready,
  output logic [(DATA_BYTES+CTRL_BYTES)*8-1:0]  rd_data,
  output logic                                  rd_sob,
  output logic                                  rd_eob,
  output logic                                  blk_err
);
  // Reset asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dbc_packer #(
    .DATA_BYTES(DATA_BYTES), .CTRL_BYTES(CTRL_BYTES), .MW_BYTES(MW_BYTES),
    .IN_WORDS(IN_WORDS), .MEM_WORDS(MEM_WORDS)
  ) u_pack (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid(wr_valid), .in_ready(wr_ready), .in_data(wr_data),
    .in_sob(wr_sob), .in_eob(wr_eob),
    .out_valid(mw_valid), .out_ready(mw_ready), .out_data(mw_data),
    .out_sob(mw_sob), .out_eob(mw_eob),
    .err(blk_err)
  );

  dbc_unpacker #(
    .DATA_BYTES(DATA_BYTES), .CTRL_BYTES(CTRL_BYTES), .MW_BYTES(MW_BYTES),
    .IN_WORDS(IN_WORDS), .MEM_WORDS(MEM_WORDS)
  ) u_unpack (
    .clk(clk), .rst_n(rst_core_n),
    .mem_valid(mr_valid), .mem_ready(mr_ready), .mem_data(mr_data),
    .mem_sob(mr_sob),
    .out_valid(rd_valid), .out_ready(rd_ready), .out_data(rd_data),
    .out_sob(rd_sob), .out_eob(rd_eob)
  );

endmodule

// File: rtl/dram_blk_codec_chk.sv
module dram_blk_codec_chk #(
  parameter int IN_WORDS  = 226,
  parameter int MEM_WORDS = 256,
  parameter int IN_W      = 72,
  parameter int MW_W      = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            wr_sob,
  input logic            mw_valid,
  input logic            mw_ready,
  input logic [MW_W-1:0] mw_data,
  input logic            mw_sob,
  input logic            mw_eob,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [IN_W-1:0] rd_data,
  input logic            blk_err
);
  logic [15:0] seen_q;
  logic [15:0] acc_q;
  logic        pad_q;
  logic        mw_fire, wr_fire;

  assign mw_fire = mw_valid && mw_ready;
  assign wr_fire = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      acc_q  <= '0;
      pad_q  <= 1'b0;
    end else begin
      if (mw_fire) seen_q <= mw_sob ? 16'd1 : seen_q + 16'd1;
      if (wr_fire) acc_q <= wr_sob ? 16'd1 : acc_q + 16'd1;
      if (wr_fire && ((wr_sob ? 16'd1 : acc_q + 16'd1) == 16'(IN_WORDS)))
        pad_q <= 1'b1;
      else if (mw_fire && mw_eob)
        pad_q <= 1'b0;
    end
  end

  AST_EOB_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_fire && mw_eob) |-> ((mw_sob ? 16'd0 : seen_q) == 16'(MEM_WORDS - 1))); // R2
  AST_MARKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> !(mw_sob && mw_eob)); // R2
  AST_PAD_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    pad_q |-> !wr_ready); // R4
  AST_MW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_data))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err |=> blk_err); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R9

endmodule

bind dram_blk_codec dram_blk_codec_chk #(
  .IN_WORDS(IN_WORDS), .MEM_WORDS(MEM_WORDS),
  .IN_W((DATA_BYTES + CTRL_BYTES) * 8), .MW_W(MW_BYTES * 8)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sob(wr_sob),
  .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_data(mw_data),
  .mw_sob(mw_sob), .mw_eob(mw_eob),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .blk_err(blk_err)
);

// File: tb/dram_blk_codec_test.sv
module dram_blk_codec_test;
  localparam int NW   = 226;
  localparam int MW   = 256;
  localparam int TOTB = NW * 9;

  logic        clk, rst_n;
  logic        wr_valid, wr_ready, wr_sob, wr_eob;
  logic [71:0] wr_data;
  logic        mw_valid, mw_ready, mw_sob, mw_eob;
  logic [63:0] mw_data;
  logic        mr_valid, mr_ready, mr_sob;
  logic [63:0] mr_data;
  logic        rd_valid, rd_ready, rd_sob, rd_eob;
  logic [71:0] rd_data;
  logic        blk_err;

  dram_blk_codec uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_sob(wr_sob), .wr_eob(wr_eob),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_data(mw_data),
    .mw_sob(mw_sob), .mw_eob(mw_eob),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_data(mr_data), .mr_sob(mr_sob),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_sob(rd_sob), .rd_eob(rd_eob),
    .blk_err(blk_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] gen_byte(int s, int w, int b);
    return 8'(w * 13 + b * 29 + s * 71 + (w >> 2) + 5);
  endfunction

  function automatic logic [71:0] in_word(int s, int w);
    logic [71:0] d;
    for (int b = 0; b < 9; b++) d[b*8 +: 8] = gen_byte(s, w, b);
    return d;
  endfunction

  function automatic logic [63:0] pk_word(int s, int j);
    logic [63:0] d;
    for (int b = 0; b < 8; b++) begin
      int k;
      k = j * 8 + b;
      d[b*8 +: 8] = (k >= TOTB) ? 8'h00 : gen_byte(s, k / 9, k % 9);
    end
    return d;
  endfunction

  // Stall pattern source
  logic [15:0] lfsr;
  bit stall_mw = 0, stall_rd = 0;
  always @(negedge clk) begin
    if (!rst_n) lfsr = 16'hACE1;
    else lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mw_ready = stall_mw ? (lfsr[1:0] != 2'b00) : 1'b1;
    rd_ready = stall_rd ? (lfsr[3:2] != 2'b00) : 1'b1;
  end

  // Capture and independent pad tracking
  logic [63:0] cw [0:2047];
  bit          csob [0:2047];
  bit          ceob [0:2047];
  int          cn = 0;
  logic [71:0] rw [0:511];
  bit          rsob [0:511];
  bit          reob [0:511];
  int          rn = 0;
  int          acc_n = 0;
  bit          in_pad = 0;
  int          pad_viol = 0, pad_cyc = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (in_pad) begin
        pad_cyc++;
        if (wr_ready) pad_viol++;
      end
      if (wr_valid && wr_ready) begin
        acc_n = wr_sob ? 1 : acc_n + 1;
        if (acc_n == NW) in_pad = 1;
      end
      if (mw_valid && mw_ready) begin
        if (cn < 2048) begin
          cw[cn] = mw_data; csob[cn] = mw_sob; ceob[cn] = mw_eob;
        end
        cn++;
        if (mw_eob) in_pad = 0;
      end
      if (rd_valid && rd_ready) begin
        if (rn < 512) begin
          rw[rn] = rd_data; rsob[rn] = rd_sob; reob[rn] = rd_eob;
        end
        rn++;
      end
    end
  end

  task automatic send_word(logic [71:0] d, bit s, bit e, bit gaps);
    @(negedge clk);
    if (gaps && lfsr[4]) begin
      wr_valid = 1'b0;
      @(negedge clk);
    end
    wr_valid = 1'b1; wr_data = d; wr_sob = s; wr_eob = e;
    forever begin
      #4;
      if (wr_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send_block(int s, int n, bit gaps);
    for (int w = 0; w < n; w++) send_word(in_word(s, w), w == 0, w == n - 1, gaps);
    @(negedge clk);
    wr_valid = 1'b0; wr_sob = 1'b0; wr_eob = 1'b0;
  endtask

  task automatic feed_mem(int base, bit gaps);
    for (int j = 0; j < MW; j++) begin
      logic [63:0] d;
      d = cw[base + j];
      if (j == MW - 2) d[63:16] = '1;
      if (j == MW - 1) d = '1;
      @(negedge clk);
      if (gaps && lfsr[5]) begin
        mr_valid = 1'b0;
        @(negedge clk);
      end
      mr_valid = 1'b1; mr_data = d; mr_sob = (j == 0);
      forever begin
        #4;
        if (mr_ready) begin
          @(posedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    mr_valid = 1'b0; mr_sob = 1'b0;
  endtask

  task automatic wait_cnt(ref int c, input int target);
    for (int t = 0; t < 5000 && c < target; t++) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic check_block(int base, int s, string tag);
    chk(cn - base == MW, {tag, " R2 word count"}, 72'(cn - base), 72'(MW));
    for (int j = 0; j < MW; j++) begin
      chk(cw[base + j] == pk_word(s, j), {tag, " R1/R5 word data"}, 72'(cw[base + j]), 72'(pk_word(s, j)));
      chk(csob[base + j] == (j == 0) && ceob[base + j] == (j == MW - 1), {tag, " R2 markers"},
          72'({csob[base + j], ceob[base + j]}), 72'({j == 0, j == MW - 1}));
    end
    chk(cw[base + MW - 2][63:16] == '0, {tag, " R3 pad in word 254"}, 72'(cw[base + MW - 2]), 72'(0));
    chk(cw[base + MW - 1] == '0, {tag, " R3 pad word 255"}, 72'(cw[base + MW - 1]), 72'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    report();
  end

  initial begin
    int base_a, base_b, base, rbase;
    rst_n = 1'b0;
    wr_valid = 0; wr_sob = 0; wr_eob = 0; wr_data = '0;
    mr_valid = 0; mr_sob = 0; mr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R10: state after reset
    chk(wr_ready == 1'b1, "R10 wr_ready", 72'(wr_ready), 72'(1));
    chk(mr_ready == 1'b1, "R10 mr_ready", 72'(mr_ready), 72'(1));
    chk(mw_valid == 1'b0, "R10 mw_valid", 72'(mw_valid), 72'(0));
    chk(rd_valid == 1'b0, "R10 rd_valid", 72'(rd_valid), 72'(0));
    chk(blk_err == 1'b0, "R10 blk_err", 72'(blk_err), 72'(0));

    // Block A: free running
    base_a = cn;
    send_block(1, NW, 0);
    wait_cnt(cn, base_a + MW);
    check_block(base_a, 1, "blockA");

    // Block B: stalls on memory side, gaps on input
    stall_mw = 1;
    base_b = cn;
    send_block(2, NW, 1);
    wait_cnt(cn, base_b + MW);
    stall_mw = 0;
    check_block(base_b, 2, "blockB");
    chk(blk_err == 1'b0, "R6 no error on framed blocks", 72'(blk_err), 72'(0));
    chk(pad_viol == 0, "R4 wr_ready low during padding", 72'(pad_viol), 72'(0));
    chk(pad_cyc > 0, "R4 padding window seen", 72'(pad_cyc), 72'(1));

    // Read side: loop block A back with padding set to ones, stalled consumer
    stall_rd = 1;
    rbase = rn;
    feed_mem(base_a, 1);
    wait_cnt(rn, rbase + NW);
    repeat (40) @(posedge clk);
    stall_rd = 0;
    chk(rn - rbase == NW, "R8 rebuilt word count, padding dropped", 72'(rn - rbase), 72'(NW));
    for (int w = 0; w < NW; w++) begin
      chk(rw[rbase + w] == in_word(1, w), "R8/R9 rebuilt word", rw[rbase + w], in_word(1, w));
      chk(rsob[rbase + w] == (w == 0) && reob[rbase + w] == (w == NW - 1), "R8 read markers",
          72'({rsob[rbase + w], reob[rbase + w]}), 72'({w == 0, w == NW - 1}));
    end

    // Short block with early end marker: error, then restart
    base = cn;
    send_block(5, 10, 0);
    repeat (10) @(posedge clk);
    #1;
    chk(blk_err == 1'b1, "R6 early end marker flags error", 72'(blk_err), 72'(1));
    chk(cn - base == 11, "R7 words from partial block", 72'(cn - base), 72'(11));
    base = cn;
    send_block(6, NW, 0);
    wait_cnt(cn, base + MW);
    check_block(base, 6, "restart R7");
    #1;
    chk(blk_err == 1'b1, "R6 error stays set", 72'(blk_err), 72'(1));

    // Reset clears the flag
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(blk_err == 1'b0, "R10 error cleared by reset", 72'(blk_err), 72'(0));
    chk(mw_valid == 1'b0, "R10 mw_valid after reset", 72'(mw_valid), 72'(0));

    report();
  end

endmodule